// File: doc/BRIEF.md
# Interrupt Controller with Wake Logic

This block gathers 32 interrupt request lines into two processor-facing outputs and one wakeup request. Each line can be enabled or left masked, and each enabled line is steered either to the normal interrupt output or to the fast interrupt output. Lines 0 to 7 carry individual GPIO edge events and line 8 carries the combined GPIO edge event. These nine lines are cleared at the GPIO block, not here. Lines 9 to 31 are level requests from peripherals; line 31 is the real-time-clock alarm. None of them needs an acknowledge: software silences a line by masking it or by clearing the condition at its peripheral.

Software reaches the block over a small register bus. A request is a one-cycle pulse, and a two-state bus state machine answers it with a one-cycle acknowledge. The registers are: an enable set, a routing set, a read-only pending view, a wake-enable set, a control word, and a read-only source-number register. The source-number register names the lowest-numbered pending line that is routed to the normal output. While the system is suspended, any active line whose wake-enable bit is set raises the wakeup output, whatever its enable bit holds. Wake-enable bits exist only for the GPIO lines 0 to 8 and the alarm line 31.

Bus state machine: ST_IDLE waits for `req`. On a request it captures the address, the direction and the data, then takes the transition IDLE->RESP. ST_RESP drives `ack`, presents the read data, and applies a write at its closing edge. It then always takes the transition RESP->IDLE. A `req` that arrives while the machine is in ST_RESP is not taken.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset, the enable, routing, wake-enable and control registers read 0, and `irq_norm`, `irq_fast` and `wake` are low.
- R2: Enable register (address 0): bit n = 1 enables line n. A line whose enable bit is 0 drives neither interrupt output.
- R3: Routing register (address 1): bit n = 0 sends enabled line n to `irq_norm`, and bit n = 1 sends it to `irq_fast`. Each output is the OR of its enabled, active, routed lines.
- R4: Pending register (address 2, read-only): it returns `src & enable` when control bit 0 is 1, and `src` unmasked when control bit 0 is 0.
- R5: Source-number register (address 5, read-only): bits [4:0] hold the number of a pending line whose routing bit is 0, and bit 31 flags it as valid. The register reads 0 when no such line is pending.
- R6: Wake-enable register (address 3): only bits 0 to 8 and bit 31 store the written value. All other bits ignore writes and read 0.
- R7: `wake` is high exactly when some active line has its wake-enable bit set. The enable register has no effect on it.
- R8: Control register (address 4): bit 0 keeps the written value and reads back. Bits 31:1 read 0.
- R9: After a request in one cycle, `ack` is high for exactly the next cycle, with the read data valid in that cycle. Writes to addresses 2 and 5 change nothing, and unused addresses read 0.
- R10: When several normal lines are pending, the source-number register reports the lowest-numbered one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | One-cycle bus request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| ack | output | 1 | One-cycle acknowledge |
| rdata | output | 32 | Read data, valid while ack is high |
| src | input | 32 | Raw interrupt lines, bit n = line n |
| irq_norm | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |
| wake | output | 1 | Wakeup request |

## Verification
A single line can drive a processor interrupt output and the wakeup output in the same cycle, and those two paths take their qualification from different registers. The bench therefore enables line 31, routes it to the fast output and sets its wake-enable bit. It then expects `irq_fast` and `wake` high together while `irq_norm` stays low. It next clears the enable register and expects `wake` to stay high while both interrupt outputs fall.

// File: rtl/iwc_pkg.sv
package iwc_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_ENABLE = 3'd0,
        RA_ROUTE  = 3'd1,
        RA_PEND   = 3'd2,
        RA_WAKE   = 3'd3,
        RA_CTRL   = 3'd4,
        RA_SRCID  = 3'd5
    } reg_addr_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } bus_state_e;
endpackage

// File: rtl/iwc_bus_fsm.sv
module iwc_bus_fsm
    import iwc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic              ack,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DW-1:0]     acc_wdata
);
    bus_state_e state_q, state_d;
    logic       we_q;

    // state register and access capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            we_q      <= 1'b0;
            acc_addr  <= '0;
            acc_wdata <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req) begin
                we_q      <= we;
                acc_addr  <= addr;
                acc_wdata <= wdata;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        ack     = 1'b0;
        wr_stb  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) state_d = ST_RESP;
            end
            ST_RESP: begin
                ack     = 1'b1;
                wr_stb  = we_q;
                state_d = ST_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/iwc_regfile.sv
module iwc_regfile
    import iwc_pkg::*;
#(
    parameter int          NSRC    = 32,
    parameter logic [31:0] WAKE_OK = 32'h8000_01FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [NSRC-1:0]   acc_wdata,
    output logic [NSRC-1:0]   enable_q,
    output logic [NSRC-1:0]   route_q,
    output logic [NSRC-1:0]   wake_en_q,
    output logic              ctrl0
);
    logic wr_enable, wr_route, wr_wake, wr_ctrl;

    assign wr_enable = wr_stb && (acc_addr == RA_ENABLE);
    assign wr_route  = wr_stb && (acc_addr == RA_ROUTE);
    assign wr_wake   = wr_stb && (acc_addr == RA_WAKE);
    assign wr_ctrl   = wr_stb && (acc_addr == RA_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            route_q  <= '0;
            ctrl0    <= 1'b0;
        end else begin
            if (wr_enable) enable_q <= acc_wdata;
            if (wr_route)  route_q  <= acc_wdata;
            if (wr_ctrl)   ctrl0    <= acc_wdata[0];
        end
    end

    // a flop only where a line may wake the system
    for (genvar i = 0; i < NSRC; i++) begin : g_wake
        if (WAKE_OK[i]) begin : g_flop
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       wake_en_q[i] <= 1'b0;
                else if (wr_wake) wake_en_q[i] <= acc_wdata[i];
            end
        end else begin : g_tie
            assign wake_en_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/iwc_lowest.sv
module iwc_lowest #(
    parameter int NSRC = 32,
    parameter int IDW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] vec,
    output logic [IDW-1:0]  id,
    output logic            valid
);
    always_comb begin
        id    = '0;
        valid = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (vec[i]) begin
                id    = IDW'(i);
                valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
    import iwc_pkg::*;
#(
    parameter int          NSRC    = 32,
    parameter logic [31:0] WAKE_OK = 32'h8000_01FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NSRC-1:0]   wdata,
    output logic              ack,
    output logic [NSRC-1:0]   rdata,
    input  logic [NSRC-1:0]   src,
    output logic              irq_norm,
    output logic              irq_fast,
    output logic              wake
);
    localparam int IDW = $clog2(NSRC);

    logic              wr_stb;
    logic [ADDR_W-1:0] acc_addr;
    logic [NSRC-1:0]   acc_wdata;
    logic [NSRC-1:0]   enable_q, route_q, wake_en_q;
    logic              ctrl0;
    logic [NSRC-1:0]   live, pend_view;
    logic [IDW-1:0]    id;
    logic              id_valid;
    logic [NSRC-1:0]   rd_mux;

    iwc_bus_fsm #(.DW(NSRC)) u_bus (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .ack(ack), .wr_stb(wr_stb),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata)
    );

    iwc_regfile #(.NSRC(NSRC), .WAKE_OK(WAKE_OK)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .enable_q(enable_q), .route_q(route_q),
        .wake_en_q(wake_en_q), .ctrl0(ctrl0)
    );

    assign live      = src & enable_q;
    assign pend_view = ctrl0 ? live : src;
    assign irq_norm  = |(live & ~route_q);
    assign irq_fast  = |(live & route_q);
    assign wake      = |(src & wake_en_q);

    iwc_lowest #(.NSRC(NSRC), .IDW(IDW)) u_enc (
        .vec(pend_view & ~route_q), .id(id), .valid(id_valid)
    );

    always_comb begin
        case (acc_addr)
            RA_ENABLE: rd_mux = enable_q;
            RA_ROUTE:  rd_mux = route_q;
            RA_PEND:   rd_mux = pend_view;
            RA_WAKE:   rd_mux = wake_en_q;
            RA_CTRL:   rd_mux = {{(NSRC-1){1'b0}}, ctrl0};
            RA_SRCID:  rd_mux = {id_valid, {(NSRC-1-IDW){1'b0}}, id};
            default:   rd_mux = '0;
        endcase
    end

    assign rdata = ack ? rd_mux : '0;
endmodule

// File: rtl/iwc_checker.sv
module iwc_checker #(
    parameter int          NSRC    = 32,
    parameter logic [31:0] WAKE_OK = 32'h8000_01FF
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req,
    input logic            ack,
    input logic [NSRC-1:0] src,
    input logic            irq_norm,
    input logic            irq_fast,
    input logic            wake,
    input logic [NSRC-1:0] enable_q,
    input logic [NSRC-1:0] route_q,
    input logic [NSRC-1:0] wake_en_q,
    input logic            ctrl0,
    input logic            id_valid
);
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack); // R9
    AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(ack) |-> $past(req)); // R9
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (enable_q == '0) |-> (!irq_norm && !irq_fast)); // R2
    AST_FAST_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n) ((route_q & enable_q) == '0) |-> !irq_fast); // R3
    AST_WAKE_BITS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) (wake_en_q & ~WAKE_OK[NSRC-1:0]) == '0); // R6
    AST_WAKE_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) wake |-> ((src & wake_en_q) != '0)); // R7
    AST_ID_MEANS_NORM: assert property (@(posedge clk) disable iff (!rst_n) (ctrl0 && id_valid) |-> irq_norm); // R5
endmodule

bind irq_wake_ctrl iwc_checker #(.NSRC(NSRC), .WAKE_OK(WAKE_OK)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .src(src),
    .irq_norm(irq_norm), .irq_fast(irq_fast), .wake(wake),
    .enable_q(enable_q), .route_q(route_q), .wake_en_q(wake_en_q),
    .ctrl0(ctrl0), .id_valid(id_valid)
);

// File: tb/sim_irq_wake_ctrl.sv
module sim_irq_wake_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0, src = '0;
    logic        ack, irq_norm, irq_fast, wake;
    logic [31:0] rdata;

    int vectors = 0, miscompares = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_wake_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .ack(ack), .rdata(rdata), .src(src),
        .irq_norm(irq_norm), .irq_fast(irq_fast), .wake(wake)
    );

    // monitor: pop one expectation per acknowledged read
    always @(negedge clk) begin
        if (ack && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            vectors++;
            if (rdata !== e.exp) begin
                miscompares++;
                $display("FAIL %s rdata=%h expected=%h", e.tag, rdata, e.exp);
            end
        end
    end

    task automatic bus_op(input logic w, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        vectors++;
        if (ack !== 1'b1) begin
            miscompares++;
            $display("FAIL R9 ack=%b expected=1", ack);
        end
        @(negedge clk);
        vectors++;
        if (ack !== 1'b0) begin
            miscompares++;
            $display("FAIL R9 ack=%b expected=0", ack);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        bus_op(1'b1, a, d);
    endtask

    task automatic bus_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        exp_t item;
        item.exp = e;
        item.tag = tag;
        sb.push_back(item);
        bus_op(1'b0, a, '0);
    endtask

    task automatic chk_out(input logic n, input logic f, input logic w, input string tag);
        #1;
        vectors++;
        if ({irq_norm, irq_fast, wake} !== {n, f, w}) begin
            miscompares++;
            $display("FAIL %s norm/fast/wake=%b%b%b expected=%b%b%b",
                     tag, irq_norm, irq_fast, wake, n, f, w);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_out(0, 0, 0, "R1 outputs after reset");
        bus_rd(3'd0, 32'h0, "R1 enable reset");
        bus_rd(3'd1, 32'h0, "R1 route reset");
        bus_rd(3'd3, 32'h0, "R1 wake reset");
        bus_rd(3'd4, 32'h0, "R1 ctrl reset");

        @(negedge clk); src = 32'h8000_0105;
        chk_out(0, 0, 0, "R2 all masked");
        bus_rd(3'd2, 32'h8000_0105, "R4 raw pending ctrl0=0");
        bus_wr(3'd4, 32'hFFFF_FFFF);
        bus_rd(3'd4, 32'h0000_0001, "R8 ctrl readback");
        bus_rd(3'd2, 32'h0, "R4 masked pending");

        bus_wr(3'd0, 32'h0000_0104);
        bus_rd(3'd2, 32'h0000_0104, "R4 enabled pending");
        chk_out(1, 0, 0, "R2 enabled normal");
        bus_rd(3'd5, 32'h8000_0002, "R10 lowest of 2 and 8");

        bus_wr(3'd1, 32'h0000_0004);
        chk_out(1, 1, 0, "R3 mixed routing");
        bus_rd(3'd5, 32'h8000_0008, "R5 fast line skipped");
        bus_wr(3'd1, 32'h0000_0104);
        chk_out(0, 1, 0, "R3 all fast");
        bus_rd(3'd5, 32'h0, "R5 none pending normal");

        bus_wr(3'd3, 32'hFFFF_FFFF);
        bus_rd(3'd3, 32'h8000_01FF, "R6 wake bits stored");
        chk_out(0, 1, 1, "R7 wake active");
        bus_wr(3'd0, 32'h0);
        chk_out(0, 0, 1, "R7 wake ignores enable");
        @(negedge clk); src = 32'h0000_0200;
        chk_out(0, 0, 0, "R6 line 9 cannot wake");

        bus_wr(3'd2, 32'hFFFF_FFFF);
        bus_wr(3'd5, 32'hFFFF_FFFF);
        bus_rd(3'd0, 32'h0, "R9 RO writes ignored");
        bus_rd(3'd7, 32'h0, "R9 unused address");

        @(negedge clk); src = 32'h8000_0000;
        bus_wr(3'd0, 32'h8000_0000);
        bus_wr(3'd1, 32'h8000_0000);
        chk_out(0, 1, 1, "R3 fast and wake together");
        bus_wr(3'd0, 32'h0);
        chk_out(0, 0, 1, "R7 wake stays after mask");

        bus_wr(3'd1, 32'h0);
        bus_wr(3'd4, 32'h0);
        bus_rd(3'd5, 32'h8000_001F, "R5 raw view ctrl0=0");

        @(negedge clk);
        vectors++;
        if (sb.size() != 0) begin
            miscompares++;
            $display("FAIL R9 reads left unanswered=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule